// File: doc/BRIEF.md
# Nested-Ratio Weighted Queue Scheduler

This block chooses which of several transmit queues may send its next frame. Each queue raises a ready flag while it holds a frame. A configuration word supplies one 4-bit weight per level. The block grants exactly one queue at a time. It holds that grant until the frame is reported finished and then makes the next decision. Over a full round the queues are served in a nested product ratio. Each level of the nesting multiplies the share of the level below it by (weight+1), so lower-numbered queues receive many more turns than higher-numbered ones.

Inside, a chain of slot counters walks through a fixed round. The counter for level 2 runs through weight-2 slots for queue 2 and one slot for queue 3. Every one of those slots is preceded by weight-1 slots for queue 1. Every slot for queue 1, 2 or 3 is preceded by weight-0 slots for queue 0. If the queue the round points at is empty, the lowest-numbered ready queue takes the slot, so no frame waits while the scheduler idles.

The default build has four queues. Queue 0 carries the greatest share, and it also wins every substitution.

Top module: `wrr_nested_sched`

## Requirements
- R1: While reset is asserted, and afterwards until some ready flag is set, `grant` is all zeros. Reset returns the round to its first slot, so the first decision after reset follows the round order from its start.
- R2: `grant` is always either all zeros or exactly one bit set. Bit k set means queue k is granted.
- R3: While `grant` is non-zero and `frame_done` is low, `grant` keeps its value, whatever the ready flags do.
- R4: A decision is taken at a clock edge in two cases: when `grant` is zero, or when `frame_done` is high. If any ready flag is set at that edge, the new grant appears on the following cycle. If `frame_done` is high and no flag is set, `grant` falls to zero. When `grant` is already zero, `frame_done` has no effect: the grant stays zero and the round position does not move.
- R5: A decision only grants a queue whose ready flag was set at the edge where the decision was taken.
- R6: Slots follow the nested order. For each level-2 slot j = 0..W2 (queue 2 when j < W2, queue 3 when j = W2), there come W1 pairs of {W0 slots for queue 0, then one slot for queue 1}, then W0 slots for queue 0, then the level-2 slot itself. The round position moves on by one for each decision.
- R7: With every queue ready, one full round grants the queues in the counts W0·(W1+1)·(W2+1), W1·(W2+1), W2 and 1 for queues 0 to 3.
- R8: A weight of zero leaves its queue with no dedicated slots, and the next level is reached at once. With all weights zero, every slot belongs to queue 3.
- R9: If the queue owning the current slot is not ready, the lowest-numbered ready queue is granted instead, and the slot still counts as used.
- R10: A new weight word is taken only at the first decision of a round. Decisions later in a round use the weights captured at its start.
- R11: W0 is `weight_cfg[3:0]`, W1 is `weight_cfg[7:4]` and W2 is `weight_cfg[11:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_ready | input | 4 | Per-queue frame-available flags, bit k for queue k |
| weight_cfg | input | 12 | Packed weights: W0 [3:0], W1 [7:4], W2 [11:8] |
| frame_done | input | 1 | Current granted frame has finished |
| grant | output | 4 | One-hot grant, all zeros when idle |

## Verification
Two things can fall on the same edge: a round boundary, where new weights are captured, and a substitution, where the slot owner is empty and another queue is granted while the slot is still used up. The bench provokes this in a directed sequence that changes weights in the middle of a round. It also provokes it in a long random run in which the ready flags, the `frame_done` strobes and occasional new weight words all change freely. A model in the bench rebuilds the full round list from the captured weights, and every cycle's grant is compared with that model. A dropped substitution, or weights taken at the wrong edge, would shift every later grant away from the list.

// File: rtl/nsched_pkg.sv
package nsched_pkg;
   localparam int unsigned NQ_DEF = 4;
   localparam int unsigned WW_DEF = 4;
   localparam int unsigned NQ_MAX = 16;
   localparam int unsigned WW_MAX = 8;
endpackage

// File: rtl/nsched_slots.sv
module nsched_slots #(
   parameter int unsigned NQ = nsched_pkg::NQ_DEF,
   parameter int unsigned WW = nsched_pkg::WW_DEF,
   localparam int unsigned NL = NQ - 1,
   localparam int unsigned CW = NL * WW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [CW-1:0] cfg_w,
   output logic [NQ-1:0] sched
);
   logic [WW-1:0] cnt_q   [NL];
   logic [WW-1:0] cnt_nxt [NL];
   logic [WW-1:0] wact_q  [NL];
   logic [WW-1:0] w_eff   [NL];
   logic [NL-1:0] below;
   logic          round_start;

   // round boundary: every level counter back at zero
   always_comb begin
      round_start = 1'b1;
      for (int i = 0; i < NL; i++) begin
         if (cnt_q[i] != '0) round_start = 1'b0;
      end
   end

   genvar gl;
   generate
      for (gl = 0; gl < NL; gl++) begin : g_lvl
         assign w_eff[gl] = round_start ? cfg_w[gl*WW +: WW] : wact_q[gl];
         assign below[gl] = (cnt_q[gl] < w_eff[gl]);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q[gl]  <= '0;
               wact_q[gl] <= '0;
            end else if (adv) begin
               cnt_q[gl]  <= cnt_nxt[gl];
               wact_q[gl] <= w_eff[gl];
            end
         end
      end
   endgenerate

   // owner of current slot: first level still below its weight
   always_comb begin
      logic found;
      sched = '0;
      found = 1'b0;
      for (int i = 0; i < NL; i++) begin
         if (!found && below[i]) begin
            sched[i] = 1'b1;
            found    = 1'b1;
         end
      end
      if (!found) sched[NQ-1] = 1'b1;
   end

   // ripple carry through the nested levels
   always_comb begin
      logic carry;
      carry = 1'b1;
      for (int i = 0; i < NL; i++) begin
         cnt_nxt[i] = cnt_q[i];
         if (carry) begin
            if (below[i]) begin
               cnt_nxt[i] = cnt_q[i] + WW'(1);
               carry      = 1'b0;
            end else begin
               cnt_nxt[i] = '0;
            end
         end
      end
   end
endmodule

// File: rtl/nsched_pick.sv
module nsched_pick #(
   parameter int unsigned NQ = nsched_pkg::NQ_DEF
) (
   input  logic [NQ-1:0] sched,
   input  logic [NQ-1:0] ready,
   output logic [NQ-1:0] choice
);
   logic [NQ-1:0] lowest;

   always_comb begin
      logic hit;
      lowest = '0;
      hit    = 1'b0;
      for (int i = 0; i < NQ; i++) begin
         if (!hit && ready[i]) begin
            lowest[i] = 1'b1;
            hit       = 1'b1;
         end
      end
   end

   assign choice = ((sched & ready) != '0) ? sched : lowest;
endmodule

// File: rtl/nsched_grant.sv
module nsched_grant #(
   parameter int unsigned NQ = nsched_pkg::NQ_DEF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_done,
   input  logic          any_ready,
   input  logic [NQ-1:0] choice,
   output logic          issue,
   output logic [NQ-1:0] grant
);
   logic idle;

   assign idle  = (grant == '0);
   assign issue = (idle || frame_done) && any_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)          grant <= '0;
      else if (issue)      grant <= choice;
      else if (frame_done) grant <= '0;
   end
endmodule

// File: rtl/wrr_nested_sched.sv
module wrr_nested_sched #(
   parameter int unsigned NQ = nsched_pkg::NQ_DEF,
   parameter int unsigned WW = nsched_pkg::WW_DEF,
   localparam int unsigned CW = (NQ - 1) * WW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NQ-1:0] q_ready,
   input  logic [CW-1:0] weight_cfg,
   input  logic          frame_done,
   output logic [NQ-1:0] grant
);
   generate
      if (NQ < 2 || NQ > nsched_pkg::NQ_MAX) begin : g_bad_nq
         $error("wrr_nested_sched: NQ out of range");
      end
      if (WW < 1 || WW > nsched_pkg::WW_MAX) begin : g_bad_ww
         $error("wrr_nested_sched: WW out of range");
      end
   endgenerate

   logic [NQ-1:0] sched;
   logic [NQ-1:0] choice;
   logic          issue;

   nsched_slots #(.NQ(NQ), .WW(WW)) slots_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (issue),
      .cfg_w (weight_cfg),
      .sched (sched)
   );

   nsched_pick #(.NQ(NQ)) pick_i (
      .sched  (sched),
      .ready  (q_ready),
      .choice (choice)
   );

   nsched_grant #(.NQ(NQ)) grant_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .any_ready  (q_ready != '0),
      .choice     (choice),
      .issue      (issue),
      .grant      (grant)
   );
endmodule

// File: rtl/nsched_chk.sv
module nsched_chk #(
   parameter int unsigned NQ = nsched_pkg::NQ_DEF
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NQ-1:0] q_ready,
   input logic          frame_done,
   input logic [NQ-1:0] grant
);
   // R2
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R3
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && !frame_done) |=> $stable(grant));

   // R4
   drop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && frame_done && q_ready == '0) |=> (grant == '0));

   // R4
   idle_wakeup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0 && q_ready != '0) |=> (grant != '0));

   // R5
   grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant == '0 || frame_done) && q_ready != '0) |=> ((grant & $past(q_ready)) != '0));

   // R9
   sole_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant == '0 || frame_done) && $onehot(q_ready)) |=> (grant == $past(q_ready)));
endmodule

bind wrr_nested_sched nsched_chk #(.NQ(NQ)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .q_ready    (q_ready),
   .frame_done (frame_done),
   .grant      (grant)
);

// File: tb/wrr_nested_sched_tb.sv
`timescale 1ns/1ps
module wrr_nested_sched_tb_top;
   logic        clk;
   logic        rst_n;
   logic [3:0]  q_ready;
   logic [11:0] weight_cfg;
   logic        frame_done;
   logic [3:0]  grant;

   int n_chk;
   int n_fail;
   bit finished;

   int seq [4096];
   int seq_len;
   int ptr;
   logic [3:0] exp_g;
   int gcnt [4];

   wrr_nested_sched dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .q_ready    (q_ready),
      .weight_cfg (weight_cfg),
      .frame_done (frame_done),
      .grant      (grant)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic build(input logic [11:0] cfg);
      int w0, w1, w2, n;
      w0 = int'(cfg[3:0]); w1 = int'(cfg[7:4]); w2 = int'(cfg[11:8]);
      n = 0;
      for (int s2 = 0; s2 <= w2; s2++) begin
         for (int k = 0; k < w1; k++) begin
            for (int j = 0; j < w0; j++) begin seq[n] = 0; n++; end
            seq[n] = 1; n++;
         end
         for (int j = 0; j < w0; j++) begin seq[n] = 0; n++; end
         seq[n] = (s2 < w2) ? 2 : 3; n++;
      end
      seq_len = n;
   endtask

   // one cycle: drive at negedge, predict, compare at next negedge
   task automatic step(input logic [3:0] r, input logic fd, input string tag);
      bit issue;
      bit subst;
      string t;
      int s;
      q_ready    = r;
      frame_done = fd;
      issue = ((exp_g == 4'b0) || fd) && (r != 4'b0);
      subst = 1'b0;
      if (issue) begin
         if (ptr == 0) build(weight_cfg);
         s = seq[ptr];
         if (r[s]) exp_g = 4'(1 << s);
         else begin
            subst = 1'b1;
            exp_g = r & (~r + 4'd1);
         end
         ptr = (ptr + 1 == seq_len) ? 0 : ptr + 1;
      end else if (fd) begin
         exp_g = 4'b0;
      end
      @(negedge clk);
      if (tag != "") t = tag;
      else if (subst) t = "R9";
      else if (issue) t = "R6";
      else if (exp_g != 4'b0) t = "R3";
      else t = "R4";
      check(grant == exp_g, t, int'(grant), int'(exp_g));
      check($onehot0(grant), "R2", int'(grant), 0);
      if (issue) check((grant & r) != 4'b0, "R5", int'(grant), int'(r));
   endtask

   task automatic do_reset();
      rst_n = 1'b0; q_ready = 4'b0; frame_done = 1'b0;
      repeat (3) @(negedge clk);
      check(grant == 4'b0, "R1", int'(grant), 0);
      rst_n = 1'b1;
      ptr = 0; exp_g = 4'b0;
   endtask

   function automatic int gidx(input logic [3:0] g);
      for (int i = 0; i < 4; i++) if (g[i]) return i;
      return 0;
   endfunction

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      n_chk = 0; n_fail = 0; finished = 1'b0;
      weight_cfg = 12'h111;
      rst_n = 1'b0; q_ready = 4'b0; frame_done = 1'b0;
      @(negedge clk);
      do_reset();
      // R1: idle until ready, then first slot of round
      step(4'b0000, 1'b0, "R1");
      step(4'b0000, 1'b1, "R4");
      step(4'b1111, 1'b0, "R1");
      check(grant == 4'b0001, "R1", int'(grant), 1);
      // R3: hold while ready flags churn
      step(4'b0000, 1'b0, "R3");
      step(4'b1010, 1'b0, "R3");
      // R4: done with nothing ready
      step(4'b0000, 1'b1, "R4");
      step(4'b0000, 1'b1, "R4");

      // R7: ratio over a full round, weights 2,1,3
      weight_cfg = 12'h312;
      do_reset();
      for (int i = 0; i < 4; i++) gcnt[i] = 0;
      step(4'b1111, 1'b0, "R7");
      gcnt[gidx(grant)]++;
      for (int i = 0; i < 23; i++) begin
         step(4'b1111, 1'b1, "R6");
         gcnt[gidx(grant)]++;
      end
      check(gcnt[0] == 16, "R7", gcnt[0], 16);
      check(gcnt[1] == 4,  "R7", gcnt[1], 4);
      check(gcnt[2] == 3,  "R7", gcnt[2], 3);
      check(gcnt[3] == 1,  "R7", gcnt[3], 1);
      step(4'b1111, 1'b1, "R7");
      check(grant == 4'b0001, "R7", int'(grant), 1);

      // R10: weight change inside a round
      weight_cfg = 12'h002;
      do_reset();
      step(4'b1111, 1'b0, "R10");
      weight_cfg = 12'h000;
      step(4'b1111, 1'b1, "R10");
      check(grant == 4'b0001, "R10", int'(grant), 1);
      step(4'b1111, 1'b1, "R10");
      check(grant == 4'b1000, "R10", int'(grant), 8);
      step(4'b1111, 1'b1, "R10");
      check(grant == 4'b1000, "R10", int'(grant), 8);

      // R8: zero weights
      weight_cfg = 12'h000;
      do_reset();
      step(4'b1111, 1'b0, "R8");
      for (int i = 0; i < 4; i++) step(4'b1111, 1'b1, "R8");
      weight_cfg = 12'h100;
      do_reset();
      step(4'b1111, 1'b0, "R8");
      check(grant == 4'b0100, "R8", int'(grant), 4);
      step(4'b1111, 1'b1, "R8");
      check(grant == 4'b1000, "R8", int'(grant), 8);

      // R9: substitution by lowest ready, slot consumed
      weight_cfg = 12'h111;
      do_reset();
      step(4'b0100, 1'b0, "R9");
      check(grant == 4'b0100, "R9", int'(grant), 4);
      step(4'b1010, 1'b1, "R9");
      check(grant == 4'b0010, "R9", int'(grant), 2);
      step(4'b1111, 1'b1, "R9");

      // R11: field positions
      weight_cfg = 12'h00F;
      do_reset();
      step(4'b1111, 1'b0, "R11");
      for (int i = 0; i < 15; i++) step(4'b1111, 1'b1, "R11");
      check(grant == 4'b1000, "R11", int'(grant), 8);
      weight_cfg = 12'h0F0;
      do_reset();
      step(4'b1111, 1'b0, "R11");
      check(grant == 4'b0010, "R11", int'(grant), 2);
      for (int i = 0; i < 15; i++) step(4'b1111, 1'b1, "R11");
      check(grant == 4'b1000, "R11", int'(grant), 8);

      // random mix against the round-list model
      void'($urandom(32'd20240611));
      weight_cfg = 12'h213;
      do_reset();
      for (int i = 0; i < 6000; i++) begin
         if (($urandom % 150) == 0) weight_cfg = 12'($urandom % 4096);
         step(4'($urandom % 16), ($urandom % 3) != 0, "");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule